// File: doc/BRIEF.md
# Data-Side Bus Request Pipelining Tracker

This block sits between the data cache control logic and the data-side system bus. It decides when a cache request may be handed to the bus. It keeps separate counts of the read requests and write requests that have been accepted but whose data has not yet completed. While an earlier request is still transferring data, the next address phase may start, as long as the per-kind limits allow it and enough cycles have passed since the slave acknowledged the previous address.

The cache presents one request at a time on a valid/ready pair. An accepted request moves into a single address stage that drives the bus request, direction and address until the slave acknowledges it. The slave later reports data completion on separate read and write completion strobes, and these free the matching slots. Reads and writes have different limits: by default two reads may be in flight, and a write may never overlap another write. Data steering and cache array updates are handled elsewhere.

Top module: `dreq_pipe_tracker`

## Requirements
- R1: During reset and in the first cycle after it, bus_req is low and req_ready is high for both a read and a write.
- R2: A request is accepted when req_valid and req_ready are both high at a clock edge. From the next cycle, bus_req is high and bus_write/bus_addr carry the accepted direction and address. These stay unchanged up to and including the cycle in which bus_ack is high, and bus_req is low in the cycle after that. req_ready stays low while bus_req is high, so requests reach the bus in acceptance order.
- R3: A read is in flight from its acceptance until a cycle with rd_done high. While MAX_RD reads (default 2) are in flight, req_ready is low for a read (req_write low). A slot freed by rd_done can be used from the following cycle.
- R4: A write (req_write high) is in flight from its acceptance until a cycle with wr_done high. While MAX_WR writes (default 1) are in flight, req_ready is low for a write. A slot freed by wr_done can be used from the following cycle.
- R5: The read and write limits are independent: a write may be accepted while reads are at their limit, and a read may be accepted while writes are at theirs.
- R6: If bus_ack is high in cycle t and any request is still in flight, the next bus_req is not high before cycle t+ACK_GAP. To achieve this, req_ready is held low until cycle t+ACK_GAP-1.
- R7: When no read and no write is in flight, the spacing of R6 does not apply, even right after an acknowledge.
- R8: rd_done with no read in flight, and wr_done with no write in flight, are ignored. The in-flight counts do not go below zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Cache presents a request |
| req_write | input | 1 | 1 = write request, 0 = read request |
| req_addr | input | AW | Request address |
| req_ready | output | 1 | Request may be accepted this cycle (for the presented kind) |
| bus_req | output | 1 | Address phase request to the slave |
| bus_write | output | 1 | Direction of the address phase, 1 = write |
| bus_addr | output | AW | Address of the address phase |
| bus_ack | input | 1 | Slave acknowledges the current address phase |
| rd_done | input | 1 | Slave completed the data of the oldest read |
| wr_done | input | 1 | Slave completed the data of the oldest write |

## Verification
A wrong in-flight count shows up at req_ready in the very cycle a request of the affected kind is presented. Too high a count stalls that kind forever. Too low a count lets a third read or a second write onto the bus one cycle after acceptance. A wrong spacing timer shows as req_ready rising one cycle early or late after an acknowledge while data is still pending, and a faulty address stage shows as bus_addr or bus_write changing before bus_ack, or bus_req not falling in the cycle after it. The bench compares req_ready and the bus outputs every cycle against a model built from the requirements, so any of these shows up within one cycle of the first stimulus that reaches it.

// File: rtl/dreq_pipe_pkg.sv
`timescale 1ns/1ps
package dreq_pipe_pkg;

   typedef enum logic {
      OP_READ  = 1'b0,
      OP_WRITE = 1'b1
   } op_e;

   // bits needed to hold the values 0..n
   function automatic int cnt_bits(input int n);
      return (n < 1) ? 1 : $clog2(n + 1);
   endfunction

endpackage

// File: rtl/dreq_inflight_ctr.sv
`timescale 1ns/1ps
// Counts requests of one kind between acceptance and data completion.
module dreq_inflight_ctr #(
   parameter int MAX = 2,
   localparam int CW = dreq_pipe_pkg::cnt_bits(MAX)
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          inc,
   input  logic          dec,
   output logic          room,
   output logic          busy,
   output logic [CW-1:0] count
);

   generate
      if (MAX < 1) begin : g_bad_max
         $error("dreq_inflight_ctr: MAX must be at least 1");
      end

      if (MAX == 1) begin : g_flag
         // single slot: a plain occupancy flag
         logic full_q;
         always_ff @(posedge clk) begin
            if (!rst_n) full_q <= 1'b0;
            else        full_q <= inc | (full_q & ~dec);
         end
         assign room  = ~full_q;
         assign busy  = full_q;
         assign count = full_q;
      end else begin : g_cnt
         logic [CW-1:0] cnt_q;
         logic          dec_ok;
         assign dec_ok = dec && (cnt_q != '0);
         always_ff @(posedge clk) begin
            if (!rst_n) cnt_q <= '0;
            else        cnt_q <= cnt_q + CW'(inc) - CW'(dec_ok);
         end
         assign room  = cnt_q < CW'(MAX);
         assign busy  = cnt_q != '0;
         assign count = cnt_q;
      end
   endgenerate

endmodule

// File: rtl/dreq_gap_timer.sv
`timescale 1ns/1ps
// Enforces the minimum distance between an address acknowledge and the
// next pipelined address phase.
module dreq_gap_timer #(
   parameter int GAP = 2
)(
   input  logic clk,
   input  logic rst_n,
   input  logic ack,
   input  logic busy,
   output logic gap_ok
);

   generate
      if (GAP < 1) begin : g_bad_gap
         $error("dreq_gap_timer: GAP must be at least 1");
      end

      if (GAP <= 2) begin : g_free
         // the address stage itself already spaces phases by two cycles
         logic unused_gap;
         assign unused_gap = ^{clk, rst_n, ack, busy};
         assign gap_ok     = 1'b1;
      end else begin : g_count
         localparam int TW = $clog2(GAP);
         logic [TW-1:0] tmr_q;
         always_ff @(posedge clk) begin
            if (!rst_n)             tmr_q <= '0;
            else if (ack)           tmr_q <= TW'(GAP - 1);
            else if (tmr_q != '0)   tmr_q <= tmr_q - TW'(1);
         end
         assign gap_ok = (tmr_q <= TW'(1)) || !busy;
      end
   endgenerate

endmodule

// File: rtl/dreq_issue_stage.sv
`timescale 1ns/1ps
// Holds one accepted request on the bus until the slave acknowledges it.
module dreq_issue_stage #(
   parameter int AW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load,
   input  logic          load_write,
   input  logic [AW-1:0] load_addr,
   input  logic          ack,
   output logic          out_valid,
   output logic          out_write,
   output logic [AW-1:0] out_addr
);

   logic          v_q;
   logic          w_q;
   logic [AW-1:0] a_q;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         v_q <= 1'b0;
         w_q <= 1'b0;
         a_q <= '0;
      end else if (load) begin
         v_q <= 1'b1;
         w_q <= load_write;
         a_q <= load_addr;
      end else if (ack && v_q) begin
         v_q <= 1'b0;
      end
   end

   assign out_valid = v_q;
   assign out_write = w_q;
   assign out_addr  = a_q;

endmodule

// File: rtl/dreq_pipe_tracker.sv
`timescale 1ns/1ps
module dreq_pipe_tracker
   import dreq_pipe_pkg::*;
#(
   parameter int AW      = 32,
   parameter int MAX_RD  = 2,
   parameter int MAX_WR  = 1,
   parameter int ACK_GAP = 2
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          req_valid,
   input  logic          req_write,
   input  logic [AW-1:0] req_addr,
   output logic          req_ready,
   output logic          bus_req,
   output logic          bus_write,
   output logic [AW-1:0] bus_addr,
   input  logic          bus_ack,
   input  logic          rd_done,
   input  logic          wr_done
);

   localparam int RCW = cnt_bits(MAX_RD);
   localparam int WCW = cnt_bits(MAX_WR);

   generate
      if (AW < 1) begin : g_bad_aw
         $error("dreq_pipe_tracker: AW must be at least 1");
      end
   endgenerate

   op_e            req_op;
   logic           accept;
   logic           kind_room;
   logic           rd_room, wr_room;
   logic           rd_busy, wr_busy;
   logic           gap_ok;
   logic [RCW-1:0] rd_cnt;
   logic [WCW-1:0] wr_cnt;

   assign req_op    = op_e'(req_write);
   assign kind_room = (req_op == OP_WRITE) ? wr_room : rd_room;
   assign req_ready = !bus_req && kind_room && gap_ok;
   assign accept    = req_valid && req_ready;

   dreq_inflight_ctr #(.MAX(MAX_RD)) u_rd_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (accept && (req_op == OP_READ)),
      .dec   (rd_done),
      .room  (rd_room),
      .busy  (rd_busy),
      .count (rd_cnt)
   );

   dreq_inflight_ctr #(.MAX(MAX_WR)) u_wr_ctr (
      .clk   (clk),
      .rst_n (rst_n),
      .inc   (accept && (req_op == OP_WRITE)),
      .dec   (wr_done),
      .room  (wr_room),
      .busy  (wr_busy),
      .count (wr_cnt)
   );

   dreq_gap_timer #(.GAP(ACK_GAP)) u_gap (
      .clk    (clk),
      .rst_n  (rst_n),
      .ack    (bus_req && bus_ack),
      .busy   (rd_busy || wr_busy),
      .gap_ok (gap_ok)
   );

   dreq_issue_stage #(.AW(AW)) u_issue (
      .clk        (clk),
      .rst_n      (rst_n),
      .load       (accept),
      .load_write (req_write),
      .load_addr  (req_addr),
      .ack        (bus_ack),
      .out_valid  (bus_req),
      .out_write  (bus_write),
      .out_addr   (bus_addr)
   );

endmodule

// File: rtl/dreq_pipe_chk.sv
`timescale 1ns/1ps
module dreq_pipe_chk #(
   parameter int AW      = 32,
   parameter int MAX_RD  = 2,
   parameter int MAX_WR  = 1,
   parameter int ACK_GAP = 2,
   parameter int RCW     = 2,
   parameter int WCW     = 1
)(
   input logic           clk,
   input logic           rst_n,
   input logic           req_valid,
   input logic           req_write,
   input logic [AW-1:0]  req_addr,
   input logic           req_ready,
   input logic           bus_req,
   input logic           bus_write,
   input logic [AW-1:0]  bus_addr,
   input logic           bus_ack,
   input logic           rd_done,
   input logic           wr_done,
   input logic [RCW-1:0] rd_count,
   input logic [WCW-1:0] wr_count
);

   generate
      if (ACK_GAP > 200) begin : g_bad_gap
         $error("dreq_pipe_chk: ACK_GAP too large for the spacing counter");
      end
   endgenerate

   logic       acc;
   logic       busy;
   logic [7:0] since_ack;
   logic       unused_chk;

   assign acc        = req_valid && req_ready;
   assign busy       = (rd_count != '0) || (wr_count != '0);
   assign unused_chk = wr_done;

   always_ff @(posedge clk) begin
      if (!rst_n)                  since_ack <= 8'hFF;
      else if (bus_req && bus_ack) since_ack <= 8'd1;
      else if (since_ack != 8'hFF) since_ack <= since_ack + 8'd1;
   end

   assert_reset_idle_R1: assert property (@(posedge clk)
      !rst_n |=> !bus_req);

   assert_issue_R2: assert property (@(posedge clk) disable iff (!rst_n)
      acc |=> bus_req && bus_addr == $past(req_addr) && bus_write == $past(req_write));

   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && !bus_ack |=> bus_req && $stable(bus_addr) && $stable(bus_write));

   assert_release_R2: assert property (@(posedge clk) disable iff (!rst_n)
      bus_req && bus_ack |=> !bus_req);

   assert_rd_limit_R3: assert property (@(posedge clk) disable iff (!rst_n)
      rd_count <= RCW'(MAX_RD));

   assert_rd_block_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (!req_write && rd_count == RCW'(MAX_RD)) |-> !req_ready);

   assert_wr_limit_R4: assert property (@(posedge clk) disable iff (!rst_n)
      wr_count <= WCW'(MAX_WR));

   assert_wr_block_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (req_write && wr_count == WCW'(MAX_WR)) |-> !req_ready);

   assert_gap_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (acc && busy) |-> since_ack >= 8'(ACK_GAP - 1));

   assert_no_underflow_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (rd_done && rd_count == '0 && !(acc && !req_write)) |=> rd_count == '0);

endmodule

bind dreq_pipe_tracker dreq_pipe_chk #(
   .AW(AW), .MAX_RD(MAX_RD), .MAX_WR(MAX_WR), .ACK_GAP(ACK_GAP),
   .RCW(RCW), .WCW(WCW)
) u_chk (
   .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
   .req_addr(req_addr), .req_ready(req_ready), .bus_req(bus_req),
   .bus_write(bus_write), .bus_addr(bus_addr), .bus_ack(bus_ack),
   .rd_done(rd_done), .wr_done(wr_done), .rd_count(rd_cnt), .wr_count(wr_cnt)
);

// File: tb/dreq_pipe_tracker_tb.sv
`timescale 1ns/1ps
module dreq_pipe_tracker_tb;

   localparam int AW   = 16;
   localparam int MAXR = 2;
   localparam int MAXW = 1;
   localparam int GAP  = 3;

   logic          clk = 1'b0;
   logic          rst_n;
   logic          req_valid, req_write;
   logic [AW-1:0] req_addr;
   logic          req_ready, bus_req, bus_write;
   logic [AW-1:0] bus_addr;
   logic          bus_ack, rd_done, wr_done;

   int checks = 0;
   int errors = 0;
   bit finished = 0;

   // model state
   bit            m_v, m_w;
   logic [AW-1:0] m_a;
   int            m_rd, m_wr, m_tmr, s_rd, s_wr;
   bit            last_acc;

   always #2.5 clk = ~clk;

   dreq_pipe_tracker #(.AW(AW), .MAX_RD(MAXR), .MAX_WR(MAXW), .ACK_GAP(GAP)) u_dut (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_write(req_write),
      .req_addr(req_addr), .req_ready(req_ready), .bus_req(bus_req),
      .bus_write(bus_write), .bus_addr(bus_addr), .bus_ack(bus_ack),
      .rd_done(rd_done), .wr_done(wr_done)
   );

   task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
      checks++;
      if (got !== exp) begin
         errors++;
         $display("FAIL %s: actual=%0h expected=%0h at %0t", tag, got, exp, $time);
      end
   endtask

   function automatic bit exp_ready(input logic w);
      bit room, spaced;
      room   = w ? (m_wr < MAXW) : (m_rd < MAXR);
      spaced = (m_tmr <= 1) || (m_rd == 0 && m_wr == 0);
      return !m_v && room && spaced;
   endfunction

   // one clock: compare with the model, advance the model, move to next negedge
   task automatic step();
      bit er, acc, ack_e, rdd, wrd;
      #1;
      er = exp_ready(req_write);
      chk("R3 R4 R5 R6 R7 req_ready vs model", req_ready, er);
      chk("R2 bus_req vs model", bus_req, m_v);
      if (m_v) begin
         chk("R2 bus_addr vs model", bus_addr, m_a);
         chk("R2 bus_write vs model", bus_write, m_w);
      end
      ack_e = bus_ack && m_v;
      acc   = req_valid && er;
      rdd   = rd_done && (m_rd > 0);
      wrd   = wr_done && (m_wr > 0);
      m_rd  = m_rd + int'(acc && !req_write) - int'(rdd);
      m_wr  = m_wr + int'(acc && req_write) - int'(wrd);
      s_rd  = s_rd + int'(ack_e && !m_w);
      s_wr  = s_wr + int'(ack_e && m_w);
      if (rd_done && s_rd > 0) s_rd--;
      if (wr_done && s_wr > 0) s_wr--;
      if (ack_e) m_tmr = GAP - 1;
      else if (m_tmr > 0) m_tmr--;
      if (acc) begin
         m_v = 1; m_w = req_write; m_a = req_addr;
      end else if (ack_e) m_v = 0;
      last_acc = acc;
      @(negedge clk);
   endtask

   task automatic idle_inputs();
      req_valid = 0; bus_ack = 0; rd_done = 0; wr_done = 0;
   endtask

   task automatic present(input logic w, input logic [AW-1:0] a);
      req_valid = 1; req_write = w; req_addr = a;
   endtask

   task automatic drain();
      for (int i = 0; i < 40; i++) begin
         if (!(m_v || s_rd > 0 || s_wr > 0 || m_rd > 0 || m_wr > 0)) break;
         req_valid = 0;
         bus_ack   = bus_req;
         rd_done   = (s_rd > 0);
         wr_done   = (s_wr > 0);
         step();
      end
      idle_inputs();
   endtask

   initial begin
      #(200000 * 5);
      if (!finished) begin
         errors++;
         checks++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

   initial begin
      void'($urandom(32'h5EED_2024));
      rst_n = 0; req_write = 0; req_addr = '0;
      idle_inputs();
      m_v = 0; m_w = 0; m_a = '0; m_rd = 0; m_wr = 0; m_tmr = 0; s_rd = 0; s_wr = 0;
      repeat (3) @(negedge clk);
      chk("R1 bus_req in reset", bus_req, 0);
      rst_n = 1;
      #1;
      chk("R1 bus_req after reset", bus_req, 0);
      req_write = 1; #0.1;
      chk("R1 ready for write after reset", req_ready, 1);
      req_write = 0; #0.1;
      chk("R1 ready for read after reset", req_ready, 1);
      @(negedge clk);

      // --- pipelined reads, read limit, write independence, write limit
      present(0, 16'h0100); #1;
      chk("R2 first read ready", req_ready, 1);
      step();
      req_valid = 0; bus_ack = 1; #1;
      chk("R2 bus_req after accept", bus_req, 1);
      chk("R2 bus_addr after accept", bus_addr, 16'h0100);
      step();
      bus_ack = 0; present(0, 16'h0104); #1;
      chk("R6 held one cycle after ack", req_ready, 0);
      step(); #1;
      chk("R6 ready at t+GAP-1", req_ready, 1);
      step();
      req_valid = 0; bus_ack = 1; step();
      bus_ack = 0; step(); step();
      present(0, 16'h0108); #1;
      chk("R3 third read blocked", req_ready, 0);
      step();
      present(1, 16'h0200); #1;
      chk("R5 write accepted while reads full", req_ready, 1);
      step();
      req_valid = 0; bus_ack = 1; step();
      bus_ack = 0; present(1, 16'h0204); step(); step(); #1;
      chk("R4 second write blocked", req_ready, 0);
      step();
      wr_done = 1; #1;
      chk("R4 slot not freed in completion cycle", req_ready, 0);
      step();
      wr_done = 0; #1;
      chk("R4 write ready after completion", req_ready, 1);
      step();
      idle_inputs();
      drain();

      // --- stray completions are ignored
      rd_done = 1; wr_done = 1; step(); step();
      idle_inputs();
      present(0, 16'h0300); step();
      req_valid = 0; bus_ack = 1; step();
      bus_ack = 0; step();
      present(0, 16'h0304); step();
      req_valid = 0; bus_ack = 1; step();
      bus_ack = 0; step(); step();
      present(0, 16'h0308); #1;
      chk("R8 limit intact after stray rd_done", req_ready, 0);
      step();
      present(1, 16'h0400); #1;
      chk("R8 write ready after stray wr_done", req_ready, 1);
      step();
      idle_inputs();
      drain();

      // --- no spacing when nothing is in flight
      present(0, 16'h0500); step();
      req_valid = 0; bus_ack = 1; rd_done = 1; step();
      idle_inputs(); present(0, 16'h0504); #1;
      chk("R7 no spacing when idle", req_ready, 1);
      step();
      idle_inputs();
      drain();

      // --- constrained random traffic
      for (int i = 0; i < 4000; i++) begin
         if (!req_valid || last_acc) begin
            req_valid = ($urandom % 4) != 0;
            req_write = ($urandom % 3) == 0;
            req_addr  = AW'($urandom);
         end
         bus_ack = bus_req && (($urandom % 3) != 0);
         rd_done = (s_rd > 0) && (($urandom % 4) == 0);
         wr_done = (s_wr > 0) && (($urandom % 4) == 0);
         step();
      end
      idle_inputs();
      drain();

      finished = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

endmodule